// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block collects interrupt requests from a set of peripheral channels. Each channel presents a source flag and an enable flag, and a channel requests service only when both are set. Each channel also carries a 3-bit priority level. A smaller level number means higher priority. Level 7 means "no interrupt". Among the requesting channels, an arbiter picks one winner and passes its level and channel index on to an acceptance stage.

The acceptance stage holds the current level mask. It accepts the winning request only when two checks pass, applied in order. First, the request's level must be strictly more urgent than the mask. Second, the global interrupt enable must be set. Acceptance also requires the instruction-boundary input to be high in the same cycle.

On acceptance the block does three things:
- it overwrites the mask with the accepted level;
- it records the winning channel;
- it pulses an accept output for one cycle.

Software can restore the mask directly, for example on return from a handler. Independently of acceptance, the block reports how many cycles interrupt entry and interrupt return take. Both counts depend on where the stack pointer points: internal or external memory, and even or odd address.

Top module: `irq_accept_unit`

## Requirements
- R1: `irq_req[i]` is high exactly when `src_flag[i]` and `en_flag[i]` are both high. It changes in the same cycle as the flags.
- R2: Among requesting channels, the winner has the numerically smallest level. On a tie, the lower channel index wins. `win_valid`, `win_chan` and `win_level` are combinational. Channel i's level is `ch_level[3*i+2:3*i]`.
- R3: A requesting channel whose level is 7 takes no part in arbitration. If no other channel requests, `win_valid` stays low.
- R4: A request is accepted only if `win_level` is strictly less than `cur_mask`. An equal or larger level is never accepted.
- R5: The global enable is checked only after the level comparison passes. A request is accepted only if `global_ie` is also high.
- R6: Acceptance requires `insn_boundary` to be high in the cycle of the deciding clock edge. `accept` is then high for the one cycle after that edge.
- R7: On acceptance, `cur_mask` takes the winner's level and `acc_chan` takes the winner's index, both visible from the cycle in which `accept` is high. A `mask_load` in the same cycle is ignored.
- R8: After reset, `cur_mask` is 7, `accept` is 0 and `acc_chan` is 0. Without an acceptance, `mask_load` writes `mask_wdata` into `cur_mask` at the next edge.
- R9: `entry_cycles` is 24+6C and `return_cycles` is 15+6C. C depends on the stack-pointer location:
  - C = 0 when `sp_internal`=1 and `sp_odd`=0;
  - C = 2 when `sp_internal`=1 and `sp_odd`=1;
  - C = `EXT_COMP` (default 1) when `sp_internal`=0.
- R10: A request stays pending while its source flag stays set. Clearing `src_flag` removes it from `irq_req` and from arbitration in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag | input | NCH | Per-channel interrupt source flags |
| en_flag | input | NCH | Per-channel interrupt enable flags |
| ch_level | input | NCH*LVLW | Per-channel priority levels, channel 0 in the lowest bits |
| global_ie | input | 1 | Global interrupt enable |
| insn_boundary | input | 1 | High on cycles where an instruction completes |
| mask_load | input | 1 | Software write strobe for the level mask |
| mask_wdata | input | LVLW | Value written by `mask_load` |
| sp_internal | input | 1 | Stack pointer addresses internal memory |
| sp_odd | input | 1 | Stack pointer address is odd |
| irq_req | output | NCH | Gated per-channel requests |
| win_valid | output | 1 | An eligible request exists |
| win_chan | output | CHW | Index of the winning channel |
| win_level | output | LVLW | Level of the winning channel |
| accept | output | 1 | One-cycle acceptance pulse |
| acc_chan | output | CHW | Channel of the last accepted request |
| cur_mask | output | LVLW | Current level mask |
| entry_cycles | output | LATW | Interrupt entry latency in cycles |
| return_cycles | output | LATW | Interrupt return latency in cycles |

## Verification
The assertions assume three things about the inputs:
- all inputs are known (not X) once reset is released;
- inputs change only away from the rising clock edge;
- the mask is written only through `mask_load`.

The bench drives every input shortly after a rising edge. Each scenario starts from a cleared request state, and the mask is set only through explicit loads or acceptances. This way each acceptance can be traced to a single qualifying edge.

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
  parameter int NCH      = 8,
  parameter int LVLW     = 3,
  parameter int EXT_COMP = 1,
  parameter int LATW     = 8,
  parameter int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       src_flag,
  input  logic [NCH-1:0]       en_flag,
  input  logic [NCH*LVLW-1:0]  ch_level,
  input  logic                 global_ie,
  input  logic                 insn_boundary,
  input  logic                 mask_load,
  input  logic [LVLW-1:0]      mask_wdata,
  input  logic                 sp_internal,
  input  logic                 sp_odd,
  output logic [NCH-1:0]       irq_req,
  output logic                 win_valid,
  output logic [CHW-1:0]       win_chan,
  output logic [LVLW-1:0]      win_level,
  output logic                 accept,
  output logic [CHW-1:0]       acc_chan,
  output logic [LVLW-1:0]      cur_mask,
  output logic [LATW-1:0]      entry_cycles,
  output logic [LATW-1:0]      return_cycles
);

  localparam logic [LVLW-1:0] NO_IRQ = {LVLW{1'b1}};

  assign irq_req = src_flag & en_flag;

  always_comb begin
    win_valid = 1'b0;
    win_chan  = '0;
    win_level = NO_IRQ;
    for (int i = 0; i < NCH; i++) begin
      if (irq_req[i] && ch_level[i*LVLW +: LVLW] != NO_IRQ &&
          (!win_valid || ch_level[i*LVLW +: LVLW] < win_level)) begin
        win_valid = 1'b1;
        win_chan  = CHW'(i);
        win_level = ch_level[i*LVLW +: LVLW];
      end
    end
  end

  logic level_ok, take;
  assign level_ok = win_valid && (win_level < cur_mask);
  assign take     = level_ok && global_ie && insn_boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mask <= NO_IRQ;
      accept   <= 1'b0;
      acc_chan <= '0;
    end else begin
      accept <= take;
      if (take) begin
        cur_mask <= win_level;
        acc_chan <= win_chan;
      end else if (mask_load) begin
        cur_mask <= mask_wdata;
      end
    end
  end

  logic [LATW-1:0] comp;
  assign comp = sp_internal ? (sp_odd ? LATW'(2) : LATW'(0)) : LATW'(EXT_COMP);
  assign entry_cycles  = LATW'(24) + LATW'(6) * comp;
  assign return_cycles = LATW'(15) + LATW'(6) * comp;

endmodule

module irq_accept_unit_chk #(
  parameter int NCH  = 8,
  parameter int LVLW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  src_flag,
  input logic [NCH-1:0]  en_flag,
  input logic            global_ie,
  input logic            insn_boundary,
  input logic            win_valid,
  input logic [LVLW-1:0] win_level,
  input logic            accept,
  input logic [LVLW-1:0] cur_mask
);

  a_r1_no_request_no_winner: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(src_flag & en_flag)) |-> !win_valid);

  a_r3_level7_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_level != {LVLW{1'b1}});

  a_r4_strictly_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(win_level) < $past(cur_mask));

  a_r5_needs_global_enable: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(global_ie));

  a_r6_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(insn_boundary));

  a_r7_mask_takes_level: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> cur_mask == $past(win_level));

endmodule

bind irq_accept_unit irq_accept_unit_chk #(.NCH(NCH), .LVLW(LVLW)) u_chk (.*);

// File: tb/irq_accept_unit_test.sv
`timescale 1ns/1ps
module irq_accept_unit_test;
  localparam int NCH = 8, LVLW = 3, CHW = 3, LATW = 8;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] src_flag = '0, en_flag = '0;
  logic [NCH*LVLW-1:0] ch_level = '1;
  logic global_ie = 0, insn_boundary = 0, mask_load = 0;
  logic [LVLW-1:0] mask_wdata = '0;
  logic sp_internal = 1, sp_odd = 0;
  logic [NCH-1:0] irq_req;
  logic win_valid, accept;
  logic [CHW-1:0] win_chan, acc_chan;
  logic [LVLW-1:0] win_level, cur_mask;
  logic [LATW-1:0] entry_cycles, return_cycles;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_accept_unit uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_lvl(input int ch, input int lvl);
    ch_level[ch*LVLW +: LVLW] = LVLW'(lvl);
  endtask

  task automatic clear_all();
    src_flag = '0; en_flag = '0; ch_level = '1;
    global_ie = 0; insn_boundary = 0; mask_load = 0;
    step();
  endtask

  task automatic load_mask(input int v);
    mask_load = 1; mask_wdata = LVLW'(v);
    step();
    mask_load = 0;
  endtask

  task automatic t_reset();
    check("R8 reset mask", cur_mask, 7);
    check("R8 reset accept", accept, 0);
    check("R8 reset acc_chan", acc_chan, 0);
  endtask

  task automatic t_gating();
    clear_all();
    set_lvl(3, 2);
    src_flag = 8'h08; #1;
    check("R1 source only", irq_req, 0);
    check("R1 source only valid", win_valid, 0);
    src_flag = 0; en_flag = 8'h08; #1;
    check("R1 enable only", irq_req, 0);
    src_flag = 8'h08; #1;
    check("R1 both set", irq_req, 8'h08);
    check("R1 winner", win_chan, 3);
  endtask

  task automatic t_arbitration();
    clear_all();
    set_lvl(2, 3); set_lvl(5, 1); set_lvl(6, 1);
    src_flag = 8'h64; en_flag = 8'h64; #1;
    check("R2 lowest level chan", win_chan, 5);
    check("R2 lowest level value", win_level, 1);
    set_lvl(2, 1); #1;
    check("R2 tie lower index", win_chan, 2);
  endtask

  task automatic t_level7();
    clear_all();
    src_flag = 8'h01; en_flag = 8'h01; #1;
    check("R3 level7 alone", win_valid, 0);
    set_lvl(4, 6); src_flag = 8'h11; en_flag = 8'h11; #1;
    check("R3 level7 excluded", win_chan, 4);
  endtask

  task automatic t_strict();
    clear_all();
    load_mask(3);
    check("R8 mask load", cur_mask, 3);
    set_lvl(1, 3); src_flag = 8'h02; en_flag = 8'h02;
    global_ie = 1; insn_boundary = 1;
    step();
    check("R4 equal level refused", accept, 0);
    check("R4 mask unchanged", cur_mask, 3);
    set_lvl(1, 2);
    step();
    check("R4 higher accepted", accept, 1);
    check("R7 mask loaded", cur_mask, 2);
    check("R7 acc_chan", acc_chan, 1);
    step();
    check("R6 single pulse", accept, 0);
  endtask

  task automatic t_global_ie();
    clear_all();
    load_mask(7);
    set_lvl(6, 4); src_flag = 8'h40; en_flag = 8'h40;
    insn_boundary = 1; global_ie = 0;
    step();
    check("R5 disabled no accept", accept, 0);
    check("R5 mask unchanged", cur_mask, 7);
    global_ie = 1;
    step();
    check("R5 enabled accept", accept, 1);
    check("R5 acc_chan", acc_chan, 6);
  endtask

  task automatic t_boundary();
    clear_all();
    load_mask(7);
    set_lvl(0, 5); src_flag = 8'h01; en_flag = 8'h01; global_ie = 1;
    step();
    check("R6 no boundary no accept", accept, 0);
    check("R6 mask unchanged", cur_mask, 7);
    insn_boundary = 1;
    step();
    check("R6 boundary accept", accept, 1);
    check("R6 mask", cur_mask, 5);
  endtask

  task automatic t_precedence();
    clear_all();
    load_mask(6);
    set_lvl(7, 1); src_flag = 8'h80; en_flag = 8'h80;
    global_ie = 1; insn_boundary = 1;
    mask_load = 1; mask_wdata = 0;
    step();
    mask_load = 0;
    check("R7 accept wins over load", accept, 1);
    check("R7 mask from accept", cur_mask, 1);
    check("R7 acc_chan", acc_chan, 7);
  endtask

  task automatic t_persist();
    clear_all();
    set_lvl(2, 4); src_flag = 8'h04; en_flag = 8'h04;
    repeat (3) step();
    check("R10 still pending", irq_req, 8'h04);
    check("R10 still winner", win_valid, 1);
    src_flag = 0; #1;
    check("R10 cleared request", irq_req, 0);
    check("R10 cleared winner", win_valid, 0);
  endtask

  task automatic t_latency();
    sp_internal = 1; sp_odd = 0; #1;
    check("R9 even entry", entry_cycles, 24);
    check("R9 even return", return_cycles, 15);
    sp_odd = 1; #1;
    check("R9 odd entry", entry_cycles, 36);
    check("R9 odd return", return_cycles, 27);
    sp_internal = 0; #1;
    check("R9 external entry", entry_cycles, 30);
    check("R9 external return", return_cycles, 21);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_gating();
    t_arbitration();
    t_level7();
    t_strict();
    t_global_ie();
    t_boundary();
    t_precedence();
    t_persist();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule